// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port Group with Grouped Interrupt

This block manages one group of eight general-purpose pins behind a 16-bit register interface. Software sets per-pin output and input enables, writes an output latch and reads back pin levels. Each pin can also be handed to a peripheral function. The peripheral then drives the pad directly, and the GPIO latch and enables no longer affect that pin.

Each pin has an interrupt flag. The flag is raised on a chosen edge of the pin's effective level, which is the synchronised pad input, or the port's own driven value when the pin is an output. A handler clears a flag by writing 1 to it. A single pending bit, which also drives the interrupt request, is the OR of all flags whose interrupt is enabled. A handler servicing several groups reads that pending bit first, then the flags.

Register offsets (`bus_addr`): 0 = data (latch in [15:8], pin status in [7:0], status read-only). 1 = enables (input enables in [15:8], output enables in [7:0]). 2 = interrupt control (edge select in [15:8], 1 = falling and 0 = rising; interrupt enables in [7:0]). 3 = flags (flags in [7:0], pending bit at [8], read-only). 4 = peripheral select in [7:0], 1 = peripheral. Reads are combinational. A write happens on a rising clock edge when `bus_sel` and `bus_wr` are both high.

Top module: `gpio_grp`

## Requirements
- R1: After reset every register reads 0x0000, `pin_oe` is 0x00 and `irq` is low.
- R2: Registers sit at the offsets and bit fields given above. Offsets 5 to 7 read 0x0000. Read-only fields and unused bits ignore writes and read 0.
- R3: For a GPIO pin, `pin_oe` follows its output enable and `pin_out` carries its latch bit. A latch written while the output is disabled holds the new value, but the pad stays undriven.
- R4: A pin whose input enable is 0 reads 0 in the data register status field, whatever the pad level.
- R5: An input-enabled GPIO pin reads the pad level two clock edges after the pad changes, through a two-flop synchroniser. When its output is also enabled, it reads its own latch bit.
- R6: When a pin's peripheral select bit is 1, `pin_out` and `pin_oe` come from `per_out` and `per_oe`, its status bit reads 0 and its flag is not set. `per_in` always equals `pin_in`.
- R7: A flag is set one edge after its effective level rises (edge select 0) or falls (edge select 1). This happens only while the pin's input is enabled and the pin is GPIO, and does not depend on the pin's interrupt enable.
- R8: Writing 1 to a flag bit at offset 3 clears that flag. Writing 0 leaves it unchanged. A new edge in the same cycle wins over the clear.
- R9: The pending bit (offset 3, bit 8) and `irq` are 1 exactly when some flag is set and its interrupt is enabled. A flag whose interrupt is disabled does not raise them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| per_out | input | 8 | Peripheral output levels |
| per_oe | input | 8 | Peripheral output enables |
| per_in | output | 8 | Pad levels passed to the peripheral |
| irq | output | 1 | Group interrupt request |

## Verification
The assertions assume that `pin_in` may change at any moment but is only trusted after synchronisation. They also assume that the bus signals are stable around each rising edge. The stimulus therefore changes every input one nanosecond after a rising edge, so each edge samples settled values. Flag checks also assume that edges are only counted while reset is released. The bench holds reset for several cycles before any pad activity, so the edge detector starts from a known low level.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;

    // register offsets on the 3-bit bus address
    typedef enum logic [2:0] {
        REG_DATA = 3'd0,
        REG_ENAB = 3'd1,
        REG_IRQC = 3'd2,
        REG_FLAG = 3'd3,
        REG_FSEL = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/gpio_grp_regs.sv
module gpio_grp_regs
    import gpio_grp_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [2:0]         bus_addr,
    input  logic [2*NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0]   out_q,
    output logic [NPINS-1:0]   oen_q,
    output logic [NPINS-1:0]   ien_q,
    output logic [NPINS-1:0]   iren_q,
    output logic [NPINS-1:0]   esel_q,
    output logic [NPINS-1:0]   fsel_q,
    output logic [NPINS-1:0]   flag_clr
);

    localparam int DW = 2 * NPINS;

    logic          wr_en;
    logic [NPINS-1:0] hi_half;
    logic [NPINS-1:0] lo_half;

    assign wr_en   = bus_sel & bus_wr;
    assign hi_half = bus_wdata[DW-1:NPINS];
    assign lo_half = bus_wdata[NPINS-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            oen_q  <= '0;
            ien_q  <= '0;
            iren_q <= '0;
            esel_q <= '0;
            fsel_q <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                REG_DATA: out_q <= hi_half;
                REG_ENAB: begin
                    ien_q <= hi_half;
                    oen_q <= lo_half;
                end
                REG_IRQC: begin
                    esel_q <= hi_half;
                    iren_q <= lo_half;
                end
                REG_FSEL: fsel_q <= lo_half;
                default: ;
            endcase
        end
    end

    // write-one-to-clear strobes for the flag register
    always_comb begin
        flag_clr = '0;
        if (wr_en && (bus_addr == REG_FLAG)) begin
            flag_clr = lo_half;
        end
    end

endmodule

// File: rtl/gpio_grp_pin.sv
module gpio_grp_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    input  logic out_bit,
    input  logic oen,
    input  logic ien,
    input  logic esel,
    input  logic fsel,
    input  logic flag_clr,
    input  logic per_out,
    input  logic per_oe,
    output logic pad_out,
    output logic pad_oe,
    output logic status,
    output logic flag
);

    logic [1:0] sync_q;
    logic       level;
    logic       level_prev;
    logic       edge_hit;

    // two-stage synchroniser on the asynchronous pad input
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[0], pad_in};
        end
    end

    // effective level: own driven value when output enabled, else pad
    assign level = oen ? out_bit : sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_prev <= 1'b0;
        end else begin
            level_prev <= level;
        end
    end

    always_comb begin
        edge_hit = 1'b0;
        if (ien && !fsel) begin
            if (esel) begin
                edge_hit = level_prev & ~level;
            end else begin
                edge_hit = level & ~level_prev;
            end
        end
    end

    // a new edge takes precedence over a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (edge_hit) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    assign status  = (ien && !fsel) ? level : 1'b0;
    assign pad_out = fsel ? per_out : out_bit;
    assign pad_oe  = fsel ? per_oe  : oen;

endmodule

// File: rtl/gpio_grp.sv
module gpio_grp
    import gpio_grp_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [2:0]         bus_addr,
    input  logic [2*NPINS-1:0] bus_wdata,
    output logic [2*NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0]   pin_in,
    output logic [NPINS-1:0]   pin_out,
    output logic [NPINS-1:0]   pin_oe,
    input  logic [NPINS-1:0]   per_out,
    input  logic [NPINS-1:0]   per_oe,
    output logic [NPINS-1:0]   per_in,
    output logic               irq
);

    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] oen_q;
    logic [NPINS-1:0] ien_q;
    logic [NPINS-1:0] iren_q;
    logic [NPINS-1:0] esel_q;
    logic [NPINS-1:0] fsel_q;
    logic [NPINS-1:0] flag_clr;
    logic [NPINS-1:0] flag_q;
    logic [NPINS-1:0] status;
    logic             pend;

    gpio_grp_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .out_q     (out_q),
        .oen_q     (oen_q),
        .ien_q     (ien_q),
        .iren_q    (iren_q),
        .esel_q    (esel_q),
        .fsel_q    (fsel_q),
        .flag_clr  (flag_clr)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gpio_grp_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .pad_in   (pin_in[g]),
            .out_bit  (out_q[g]),
            .oen      (oen_q[g]),
            .ien      (ien_q[g]),
            .esel     (esel_q[g]),
            .fsel     (fsel_q[g]),
            .flag_clr (flag_clr[g]),
            .per_out  (per_out[g]),
            .per_oe   (per_oe[g]),
            .pad_out  (pin_out[g]),
            .pad_oe   (pin_oe[g]),
            .status   (status[g]),
            .flag     (flag_q[g])
        );
    end

    assign pend   = |(flag_q & iren_q);
    assign irq    = pend;
    assign per_in = pin_in;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_DATA: bus_rdata = {out_q, status};
            REG_ENAB: bus_rdata = {ien_q, oen_q};
            REG_IRQC: bus_rdata = {esel_q, iren_q};
            REG_FLAG: bus_rdata = {{(NPINS-1){1'b0}}, pend, flag_q};
            REG_FSEL: bus_rdata = {{NPINS{1'b0}}, fsel_q};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_grp_chk.sv
module gpio_grp_chk #(
    parameter int NPINS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [2:0]         bus_addr,
    input logic [2*NPINS-1:0] bus_rdata,
    input logic [NPINS-1:0]   pin_out,
    input logic [NPINS-1:0]   pin_oe,
    input logic [NPINS-1:0]   per_out,
    input logic [NPINS-1:0]   per_oe,
    input logic               irq,
    input logic [NPINS-1:0]   out_q,
    input logic [NPINS-1:0]   oen_q,
    input logic [NPINS-1:0]   ien_q,
    input logic [NPINS-1:0]   iren_q,
    input logic [NPINS-1:0]   fsel_q,
    input logic [NPINS-1:0]   flag_q
);

    localparam int DW = 2 * NPINS;

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0) && !irq);

    a_r2_fsel_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd4) |-> (bus_rdata[DW-1:NPINS] == '0));

    a_r3_gpio_pad_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_oe ^ oen_q) & ~fsel_q) == '0) && (((pin_out ^ out_q) & ~fsel_q) == '0));

    a_r4_disabled_input_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd0) |-> ((bus_rdata[NPINS-1:0] & (~ien_q | fsel_q)) == '0));

    a_r6_periph_pad_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_oe ^ per_oe) & fsel_q) == '0) && (((pin_out ^ per_out) & fsel_q) == '0));

    a_r7_set_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(ien_q & ~fsel_q)) == '0));

    a_r8_flags_fall_only_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && (bus_addr == 3'd3)) |=> (($past(flag_q) & ~flag_q) == '0));

    a_r9_pending_read_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd3) |-> (bus_rdata[NPINS] == irq));

    a_r9_irq_needs_enabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ((flag_q & iren_q) != '0));

endmodule

bind gpio_grp gpio_grp_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .per_out   (per_out),
    .per_oe    (per_oe),
    .irq       (irq),
    .out_q     (out_q),
    .oen_q     (oen_q),
    .ien_q     (ien_q),
    .iren_q    (iren_q),
    .fsel_q    (fsel_q),
    .flag_q    (flag_q)
);

// File: tb/gpio_grp_tb.sv
`timescale 1ns/1ps
module gpio_grp_tb;

    localparam int N  = 8;
    localparam int DW = 2 * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  per_out = '0;
    logic [N-1:0]  per_oe = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic [N-1:0]  per_in;
    logic          irq;

    gpio_grp #(.NPINS(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .per_out   (per_out),
        .per_oe    (per_oe),
        .per_in    (per_in),
        .irq       (irq)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // ---------------- behavioural reference model ----------------
    logic [N-1:0] m_out = '0, m_oen = '0, m_ien = '0, m_iren = '0;
    logic [N-1:0] m_esel = '0, m_fsel = '0, m_flag = '0;
    logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
    logic [N-1:0] t_lvl, t_flag;

    function automatic logic [N-1:0] mdl_level();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_oen[i] ? m_out[i] : m_s2[i];
        return v;
    endfunction

    function automatic logic [N-1:0] mdl_status();
        logic [N-1:0] v, l;
        l = mdl_level();
        for (int i = 0; i < N; i++) v[i] = (m_ien[i] && !m_fsel[i]) ? l[i] : 1'b0;
        return v;
    endfunction

    function automatic logic mdl_pend();
        logic p = 1'b0;
        for (int i = 0; i < N; i++) if (m_flag[i] && m_iren[i]) p = 1'b1;
        return p;
    endfunction

    function automatic logic [DW-1:0] mdl_read(input logic [2:0] a);
        case (a)
            3'd0: return {m_out, mdl_status()};
            3'd1: return {m_ien, m_oen};
            3'd2: return {m_esel, m_iren};
            3'd3: return {{(N-1){1'b0}}, mdl_pend(), m_flag};
            3'd4: return {{N{1'b0}}, m_fsel};
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out <= '0; m_oen <= '0; m_ien <= '0; m_iren <= '0;
            m_esel <= '0; m_fsel <= '0; m_flag <= '0;
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
        end else begin
            t_lvl  = mdl_level();
            t_flag = m_flag;
            for (int i = 0; i < N; i++) begin
                if (bus_sel && bus_wr && bus_addr == 3'd3 && bus_wdata[i]) t_flag[i] = 1'b0;
                if (m_ien[i] && !m_fsel[i]) begin
                    if (!m_esel[i] && t_lvl[i] && !m_prev[i]) t_flag[i] = 1'b1;
                    if (m_esel[i] && !t_lvl[i] && m_prev[i]) t_flag[i] = 1'b1;
                end
            end
            m_flag <= t_flag;
            m_prev <= t_lvl;
            m_s2   <= m_s1;
            m_s1   <= pin_in;
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    3'd0: m_out <= bus_wdata[DW-1:N];
                    3'd1: begin m_ien <= bus_wdata[DW-1:N]; m_oen <= bus_wdata[N-1:0]; end
                    3'd2: begin m_esel <= bus_wdata[DW-1:N]; m_iren <= bus_wdata[N-1:0]; end
                    3'd4: m_fsel <= bus_wdata[N-1:0];
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2 R4 R5 R6 data read";
            3'd3: return "R7 R8 R9 flag read";
            default: return "R2 register read";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [N-1:0] eo, ee;
            for (int i = 0; i < N; i++) begin
                eo[i] = m_fsel[i] ? per_out[i] : m_out[i];
                ee[i] = m_fsel[i] ? per_oe[i]  : m_oen[i];
            end
            check(rd_tag(bus_addr), bus_rdata, mdl_read(bus_addr));
            check("R3 R6 pin_out", {{N{1'b0}}, pin_out}, {{N{1'b0}}, eo});
            check("R3 R6 pin_oe",  {{N{1'b0}}, pin_oe},  {{N{1'b0}}, ee});
            check("R6 per_in",     {{N{1'b0}}, per_in},  {{N{1'b0}}, pin_in});
            check("R9 irq",        {{(DW-1){1'b0}}, irq}, {{(DW-1){1'b0}}, mdl_pend()});
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic xchk(input string tag, input logic [2:0] a, input logic [DW-1:0] exp);
        bus_addr = a;
        @(negedge clk);
        check(tag, bus_rdata, exp);
        tick();
    endtask

    task automatic portchk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        check(tag, {{N{1'b0}}, act}, {{N{1'b0}}, exp});
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 5; a++) xchk("R1 reset value", 3'(a), 16'h0000);
        @(negedge clk);
        portchk("R1 pin_oe after reset", pin_oe, 8'h00);
        portchk("R1 irq after reset", {7'b0, irq}, 8'h00);
        tick();
        xchk("R2 unmapped offset", 3'd6, 16'h0000);

        // R3: latch written while undriven, then driven
        wr(3'd0, 16'hA5FF);
        xchk("R3 latch holds, status ignores write (R2)", 3'd0, 16'hA500);
        @(negedge clk);
        portchk("R3 pad undriven", pin_oe, 8'h00);
        tick();
        wr(3'd1, 16'h00FF);
        @(negedge clk);
        portchk("R3 pad drives latch", pin_out, 8'hA5);
        portchk("R3 pad enabled", pin_oe, 8'hFF);
        tick();

        // R4/R5: input enables and synchroniser latency
        wr(3'd1, 16'h0F00);
        pin_in = 8'hFF;
        bus_addr = 3'd0;
        @(negedge clk); check("R5 no change before first flop", bus_rdata, 16'hA500);
        @(negedge clk); check("R5 no change after one edge", bus_rdata, 16'hA500);
        @(negedge clk); check("R4 R5 masked pad level", bus_rdata, 16'hA50F);
        tick();
        xchk("R7 R9 rising edge flags, no pending while disabled", 3'd3, 16'h000F);

        // R5: loopback of own driven value
        wr(3'd1, 16'hFFFF);
        wr(3'd0, 16'h3C00);
        pin_in = 8'h00;
        xchk("R5 loopback reads latch", 3'd0, 16'h3C3C);
        repeat (3) tick();

        // R8/R9: write-one-to-clear and summary
        wr(3'd3, 16'h00FF);
        xchk("R8 clear all flags", 3'd3, 16'h0000);
        wr(3'd2, 16'h0003);
        wr(3'd0, 16'h0300);
        xchk("R7 flag lags edge by one clock", 3'd3, 16'h0000);
        xchk("R7 R9 rising flags pending", 3'd3, 16'h0103);
        wr(3'd3, 16'h0000);
        xchk("R8 writing 0 keeps flags", 3'd3, 16'h0103);
        wr(3'd3, 16'h0001);
        xchk("R8 R9 other enabled flag keeps pending", 3'd3, 16'h0102);
        wr(3'd3, 16'h0002);
        xchk("R9 pending drops with last flag", 3'd3, 16'h0000);

        // R7: falling-edge selection
        wr(3'd2, 16'h0404);
        wr(3'd0, 16'h0700);
        wr(3'd0, 16'h0300);
        tick();
        xchk("R7 falling edge sets flag", 3'd3, 16'h0104);

        // R6: peripheral takeover
        per_out = 8'h5A;
        per_oe = 8'hC3;
        pin_in = 8'hFF;
        wr(3'd4, 16'hFFF0);
        @(negedge clk);
        portchk("R6 pad out from peripheral", pin_out, 8'h53);
        portchk("R6 pad oe from peripheral", pin_oe, 8'hCF);
        portchk("R6 per_in follows pad", per_in, 8'hFF);
        tick();
        xchk("R6 status hidden, R2 select upper bits", 3'd4, 16'h00F0);
        xchk("R6 status bits read 0", 3'd0, 16'h0303);

        // mixed traffic against the model
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 3) begin
                wr(3'($urandom_range(0, 4)), 16'($urandom));
            end else begin
                pin_in   = 8'($urandom);
                per_out  = 8'($urandom);
                per_oe   = 8'($urandom);
                bus_addr = 3'($urandom_range(0, 7));
                tick();
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule